// File: doc/BRIEF.md
# Filtered Masked Limit Input Latch

This block conditions the fail-safe switch inputs of a motion controller: a bank of limit switches plus a bank of special inputs (pause, emergency stop and several general-purpose inputs). Every input is synchronised and passed through a slow two-sample debounce filter running on a tick of tens of milliseconds, so short noise bursts on long field cables are rejected while a real switch event is always seen.

Limits are gated by a software-written enable mask. With limit checking switched on, the first filtered limit pattern that hits an enabled bit is captured and held, and a halt request is raised; the emergency stop raises the same halt request directly and ignores the mask. A small register port lets software write the mask, the mode bit and a clear strobe, and read back either the raw limit inputs (checking off) or the filtered, masked or captured limit value (checking on), together with a status word carrying the filtered special inputs and a captured-or-live flag. All ports are plain control and status signals; there is no streamed data and no back-pressure.

Top module: `limit_guard`

## Requirements
- R1: Inputs are fail-safe: a pin at 1 means current flows (inactive); a pin at 0 (open loop) is an active input and reads back as 1.
- R2: A change of an input level is taken into the filtered value only when two consecutive tick samples agree; a pulse shorter than one tick period never reaches the filtered value, and a pulse held for two tick periods plus three clock cycles always does.
- R3: With checking off (control bit 0 = 0), reading address 0 returns the synchronised, unfiltered active levels of the limits, two clock cycles after a pin change.
- R4: With checking on, only limits whose bit is 1 in the mask (write address 0, read address 2) can trigger; a limit with mask bit 0 never causes capture or halt, and while nothing is captured address 0 reads filtered limits ANDed with the mask.
- R5: With checking on and nothing captured, the first non-zero filtered-and-masked limit value is captured; address 0 then returns that captured value unchanged while the inputs or the mask change.
- R6: A write to address 2 (any data), or turning checking off, releases the capture; the capture re-arms, so a still-present enabled limit is captured again one cycle later.
- R7: Reading address 1 returns bit 0 = capture flag, bit 1 = filtered pause, bit 2 = filtered emergency stop, bits 3 to 7 = filtered miscellaneous inputs 0 to 4.
- R8: The halt request output is 1 exactly while a limit value is captured or the filtered emergency stop is active.
- R9: Pause and emergency stop are filtered like the limits but never depend on the mask or on the checking mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| limit_loop | input | NUM_LIMITS | Limit loop current, 1 = current flows |
| pause_loop | input | 1 | Pause loop current, 1 = current flows |
| estop_loop | input | 1 | Emergency stop loop current, 1 = current flows |
| misc_loop | input | NUM_MISC | Miscellaneous loop current, 1 = current flows |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mask, 1 control, 2 clear |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address: 0 limits, 1 status, 2 mask, 3 control |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| halt_req | output | 1 | Halt request |

## Verification
A raw readback is due two clock edges after a pin change and is sampled on the third falling edge; a filtered result is due no later than two tick periods plus the synchroniser delay, so after every pin change the bench waits a settling window of three tick periods plus margin before it compares. Register writes land on the next rising edge and a capture follows one cycle later, so read data and halt are compared a few cycles after each write. Glitches are held for fewer cycles than one tick and are compared only after a full settling window, when a wrongly accepted glitch would still be visible.

// File: rtl/limg_pkg.sv
package limg_pkg;
  typedef enum logic [1:0] {
    WA_MASK  = 2'd0,
    WA_CTRL  = 2'd1,
    WA_CLEAR = 2'd2,
    WA_NONE  = 2'd3
  } wr_addr_e;

  typedef enum logic [1:0] {
    RA_LIMIT  = 2'd0,
    RA_STATUS = 2'd1,
    RA_MASK   = 2'd2,
    RA_CTRL   = 2'd3
  } rd_addr_e;
endpackage

// File: rtl/limg_tick.sv
module limg_tick #(
  parameter int TICK_CYCLES = 8_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/limg_filter.sv
module limg_filter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] act_in,
  output logic [W-1:0] act_sync,
  output logic [W-1:0] act_filt
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q, samp_q, filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        samp_q <= 1'b0;
        filt_q <= 1'b0;
      end else begin
        s1_q <= act_in[i];
        s2_q <= s1_q;
        if (tick) begin
          samp_q <= s2_q;
          if (s2_q == samp_q) begin
            filt_q <= s2_q;
          end
        end
      end
    end

    assign act_sync[i] = s2_q;
    assign act_filt[i] = filt_q;
  end
endmodule

// File: rtl/limg_capture.sv
module limg_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         check_en,
  input  logic         clear,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] filt,
  output logic         held,
  output logic [W-1:0] held_val
);
  logic [W-1:0] trig;
  assign trig = filt & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_val <= '0;
    end else if (!check_en || clear) begin
      held     <= 1'b0;
      held_val <= '0;
    end else if (!held && (trig != '0)) begin
      held     <= 1'b1;
      held_val <= trig;
    end
  end
endmodule

// File: rtl/limit_guard.sv
module limit_guard
  import limg_pkg::*;
#(
  parameter int NUM_LIMITS  = 8,
  parameter int NUM_MISC    = 5,
  parameter int DATA_W      = 8,
  parameter int TICK_CYCLES = 8_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LIMITS-1:0] limit_loop,
  input  logic                  pause_loop,
  input  logic                  estop_loop,
  input  logic [NUM_MISC-1:0]   misc_loop,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [1:0]            rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  halt_req
);
  localparam int NUM_SPECIAL = 2 + NUM_MISC;
  localparam int NUM_ALL     = NUM_LIMITS + NUM_SPECIAL;
  localparam int SP_PAUSE    = 0;
  localparam int SP_ESTOP    = 1;

  // Fail-safe: no loop current means the input is active.
  logic [NUM_ALL-1:0] act_in, act_sync, act_filt;
  assign act_in = ~{misc_loop, estop_loop, pause_loop, limit_loop};

  logic tick;
  limg_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk (clk), .rst_n (rst_n), .tick (tick)
  );

  limg_filter #(.W(NUM_ALL)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .act_in   (act_in),
    .act_sync (act_sync),
    .act_filt (act_filt)
  );

  logic [NUM_LIMITS-1:0]  lim_raw, lim_filt;
  logic [NUM_SPECIAL-1:0] sp_filt;
  assign lim_raw  = act_sync[NUM_LIMITS-1:0];
  assign lim_filt = act_filt[NUM_LIMITS-1:0];
  assign sp_filt  = act_filt[NUM_ALL-1:NUM_LIMITS];

  // Register port
  logic [NUM_LIMITS-1:0] mask_q;
  logic                  check_en_q;
  logic                  clear_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      check_en_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr_e'(wr_addr))
        WA_MASK: mask_q     <= wr_data[NUM_LIMITS-1:0];
        WA_CTRL: check_en_q <= wr_data[0];
        default: ;
      endcase
    end
  end

  assign clear_stb = wr_en && (wr_addr_e'(wr_addr) == WA_CLEAR);

  logic                  held;
  logic [NUM_LIMITS-1:0] held_val;

  limg_capture #(.W(NUM_LIMITS)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .check_en (check_en_q),
    .clear    (clear_stb),
    .mask     (mask_q),
    .filt     (lim_filt),
    .held     (held),
    .held_val (held_val)
  );

  logic estop_filt;
  assign estop_filt = sp_filt[SP_ESTOP];
  assign halt_req   = held || estop_filt;

  // Readback multiplexer
  logic [NUM_LIMITS-1:0] lim_view;
  always_comb begin
    if (!check_en_q)  lim_view = lim_raw;
    else if (held)    lim_view = held_val;
    else              lim_view = lim_filt & mask_q;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr_e'(rd_addr))
      RA_LIMIT:  rd_data[NUM_LIMITS-1:0] = lim_view;
      RA_STATUS: begin
        rd_data[0]             = held;
        rd_data[NUM_SPECIAL:1] = sp_filt;
      end
      RA_MASK:   rd_data[NUM_LIMITS-1:0] = mask_q;
      default:   rd_data[0] = check_en_q;
    endcase
  end

  logic unused_pause;
  assign unused_pause = sp_filt[SP_PAUSE];
endmodule

// File: rtl/limit_guard_chk.sv
module limit_guard_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] filt,
  input logic         check_en,
  input logic         clear,
  input logic [W-1:0] mask,
  input logic         held,
  input logic [W-1:0] held_val,
  input logic         estop_filt,
  input logic         halt
);
  // R2: filtered levels move only on a tick
  a_r2_filter_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(filt));

  // R4: a fresh capture holds only masked bits
  a_r4_capture_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> ((held_val & ~$past(mask)) == '0) && (held_val != '0));

  // R5: a captured value stays unchanged while held
  a_r5_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(held_val));

  // R6: checking off or a clear releases the capture
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!check_en || clear) |=> !held);

  // R8: halt only with a cause
  a_r8_halt_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (held || estop_filt));
endmodule

bind limit_guard limit_guard_chk #(.W(NUM_LIMITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .filt       (lim_filt),
  .check_en   (check_en_q),
  .clear      (clear_stb),
  .mask       (mask_q),
  .held       (held),
  .held_val   (held_val),
  .estop_filt (estop_filt),
  .halt       (halt_req)
);

// File: tb/limit_guard_tb_top.sv
module limit_guard_tb_top;
  localparam int NL = 8;
  localparam int NM = 5;
  localparam int DW = 8;
  localparam int TK = 16;
  localparam int SETTLE = 3 * TK + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] limit_loop = '1;
  logic pause_loop = 1'b1, estop_loop = 1'b1;
  logic [NM-1:0] misc_loop = '1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic halt_req;

  always #2 clk = ~clk;

  limit_guard #(.NUM_LIMITS(NL), .NUM_MISC(NM), .DATA_W(DW), .TICK_CYCLES(TK)) dut_i (
    .clk(clk), .rst_n(rst_n), .limit_loop(limit_loop), .pause_loop(pause_loop),
    .estop_loop(estop_loop), .misc_loop(misc_loop), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .halt_req(halt_req)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Model of the requirements at settled points
  logic [NL-1:0] m_mask = '0, m_lat = '0, a_lim = '0;
  logic [6:0]    a_sp = '0;
  bit m_en = 0, m_held = 0;

  function automatic logic [DW-1:0] exp_limit_rd();
    if (!m_en)       return a_lim;
    else if (m_held) return m_lat;
    else             return a_lim & m_mask;
  endfunction

  function automatic logic [DW-1:0] exp_status();
    return {a_sp, m_held};
  endfunction

  function automatic bit exp_halt();
    return m_held || a_sp[1];
  endfunction

  task automatic cmp(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rearm_model();
    if (m_en && !m_held && ((a_lim & m_mask) != '0)) begin
      m_held = 1;
      m_lat  = a_lim & m_mask;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic check_all(input string req);
    logic [DW-1:0] d;
    rd(2'd0, d); cmp({req, " limit read"}, d, exp_limit_rd());
    rd(2'd1, d); cmp({req, " status"}, d, exp_status());
    cmp({req, " halt"}, {7'd0, halt_req}, {7'd0, exp_halt()});
  endtask

  task automatic set_mask(input logic [NL-1:0] v);
    wr(2'd0, v); m_mask = v; rearm_model();
  endtask
  task automatic set_en(input bit b);
    wr(2'd1, {7'd0, b}); m_en = b;
    if (!b) begin m_held = 0; m_lat = '0; end
    rearm_model();
  endtask
  task automatic do_clear();
    wr(2'd2, 8'hA5); m_held = 0; m_lat = '0; rearm_model();
  endtask

  task automatic drive(input logic [NL-1:0] lim, input logic [6:0] sp);
    limit_loop = ~lim;
    {misc_loop, estop_loop, pause_loop} = ~sp;
  endtask

  task automatic set_inputs(input logic [NL-1:0] lim, input logic [6:0] sp);
    @(negedge clk);
    drive(lim, sp);
    repeat (SETTLE) @(negedge clk);
    a_lim = lim; a_sp = sp; rearm_model();
  endtask

  task automatic glitch(input logic [NL-1:0] lim, input logic [6:0] sp, input int w);
    @(negedge clk);
    drive(lim, sp);
    repeat (w) @(negedge clk);
    drive(a_lim, a_sp);
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [DW-1:0] d;
    void'($urandom(32'h1A2B3C));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (SETTLE) @(negedge clk);

    // R1 R7 R8: reset state with all loops closed
    check_all("R1 reset");
    rd(2'd2, d); cmp("R4 reset mask", d, 8'h00);
    rd(2'd3, d); cmp("R6 reset ctrl", d, 8'h00);

    // R3 R1: raw readback two cycles after a pin opens, before filtering
    @(negedge clk); drive(8'h09, 7'd0);
    repeat (3) @(negedge clk);
    rd_addr = 2'd0; #1 cmp("R3 raw read", rd_data, 8'h09);
    drive(8'h00, 7'd0);
    repeat (SETTLE) @(negedge clk);
    check_all("R2 short pulse rejected");

    // R4: mask of 15 enables first four limits
    set_mask(8'h0F);
    set_en(1);
    set_inputs(8'hF0, 7'd0);
    check_all("R4 unmasked limits ignored");
    set_inputs(8'hF4, 7'd0);
    check_all("R5 first pattern captured");
    set_inputs(8'hF6, 7'd0);
    check_all("R5 capture unchanged by inputs");
    set_mask(8'hFF);
    check_all("R5 capture unchanged by mask");

    // R6: clear with limit still present re-captures
    do_clear();
    check_all("R6 clear re-arms");
    set_inputs(8'h00, 7'd0);
    do_clear();
    check_all("R6 clear releases");

    // R2: glitch below one tick rejected, threshold pulse captured
    glitch(8'h40, 7'd0, TK - 1);
    check_all("R2 glitch rejected");
    glitch(8'h20, 7'd0, 2 * TK + 3);
    m_held = 1; m_lat = 8'h20;
    check_all("R2 threshold pulse detected");
    set_en(0);
    check_all("R6 off releases");

    // R9: estop and pause ignore mask and mode
    set_mask(8'h00);
    set_inputs(8'h00, 7'b0000110);
    check_all("R9 estop halts off mode");
    set_en(1);
    set_inputs(8'hFF, 7'b1010110);
    check_all("R9 estop halts with mask zero");
    set_inputs(8'h00, 7'd0);
    check_all("R8 halt drops");

    // Random phase
    for (int i = 0; i < 40; i++) begin
      int k = $urandom_range(0, 5);
      case (k)
        0: set_mask(8'($urandom));
        1: set_en(bit'($urandom_range(0, 1)));
        2: do_clear();
        3: glitch(8'($urandom), 7'($urandom), $urandom_range(1, TK - 1));
        default: set_inputs(8'($urandom) & 8'($urandom), 7'($urandom) & 7'($urandom));
      endcase
      check_all("R5 R6 R9 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule